// File: doc/BRIEF.md
# Buffered Input Capture Channel

This block is a single timer input-capture channel. It watches one asynchronous input pin. When a chosen edge arrives it takes a snapshot of an externally supplied free-running timer value. The pin is first brought into the clock domain. An optional delay filter can then demand that the new level stay in place for 256, 512 or 1024 clocks before the edge counts. Edges that survive the filter and the edge selection are called accepted edges.

Behind the capture register sits a holding register, which works in one of two ways. In queue mode it keeps a two-deep history of captures. In latch mode it takes a copy of the capture register when an outside strobe or a force bit asks for one. A no-overwrite mode stops unread values from being replaced. A flag-on-transfer mode lets software wait until two values have been gathered. The channel also reports a status flag, the polarity of the first capture, and an interrupt request gated by an enable.

Top module: `bufcap_chan`

## Requirements
- R1: After synchronous reset, `cap_o`, `hold_o`, `flag_o`, `pol_o` and `irq_o` are all 0.
- R2: `edge_sel_i` picks the edges that are accepted: 2'b00 accepts none, 2'b01 accepts only rising edges (pin 0 to 1), 2'b10 accepts only falling edges, and 2'b11 accepts both.
- R3: With the filter off, suppose the pin changes before rising edge E1. The accepted edge writes the `timer_i` value present at E4 into `cap_o` at E4 and sets `flag_o` at the same edge. `cap_o` changes only on an accepted edge.
- R4: When `dly_sel_i` is nonzero, a pin transition starts a count of 256 clocks (code 2'b01), 512 clocks (2'b10) or 1024 clocks (2'b11). Each further change of the synchronised level restarts the count. The edge is accepted only if, when the count ends, the level is still opposite to the level before the transition. Pulses shorter than the count are therefore rejected.
- R5: A cycle with `flag_clr_i` high and no flag-setting event clears `flag_o`. A setting event in the same cycle wins over the clear.
- R6: In queue mode (`buf_en_i`=1, `latch_mode_i`=0) with no-overwrite off, each accepted edge first moves the old `cap_o` into `hold_o` and then loads the new timer value into `cap_o`.
- R7: In latch mode (`buf_en_i`=1, `latch_mode_i`=1), accepted edges update only `cap_o`. A cycle with `latch_stb_i` or `force_latch_i` high copies `cap_o` into `hold_o`.
- R8: With `no_ovw_i`=1, a full capture register is not overwritten. A write fills it. A `cap_rd_i` pulse or a latch empties it. A full holding register is not overwritten in queue mode either; a write fills it and a `hold_rd_i` pulse empties it. In queue mode an edge loads only `cap_o` while it is empty. The edge shifts while the holding register is empty, and is dropped when both registers are full.
- R9: In queue mode with `flag_hold_i`=1, `flag_o` is set only by a transfer into `hold_o`, not by a capture that leaves `hold_o` unchanged.
- R10: When `cap_o` is written while `flag_o` is 0, `pol_o` takes 1 for a rising edge and 0 for a falling edge. Writes made while `flag_o` is 1 leave `pol_o` unchanged.
- R11: With `fast_clr_i`=1, a `cap_rd_i` pulse clears `flag_o`. With `fast_clr_i`=0 the read leaves the flag alone.
- R12: With `buf_en_i`=0 the channel is a plain single-register capture and `hold_o` never changes.
- R13: `irq_o` is high exactly when `flag_o` and `ie_i` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 1 | Asynchronous capture pin |
| timer_i | input | TW (16) | Free-running timer value |
| edge_sel_i | input | 2 | Edge selection |
| dly_sel_i | input | 2 | Delay filter length selection |
| buf_en_i | input | 1 | Enable the holding register |
| latch_mode_i | input | 1 | 1 = latch mode, 0 = queue mode |
| no_ovw_i | input | 1 | Protect unread registers from overwrite |
| flag_hold_i | input | 1 | Queue mode: set the flag on a transfer into hold |
| fast_clr_i | input | 1 | Let capture reads clear the flag |
| ie_i | input | 1 | Interrupt enable |
| latch_stb_i | input | 1 | External latch strobe |
| force_latch_i | input | 1 | Software force-latch pulse |
| flag_clr_i | input | 1 | Write-one-to-clear pulse for the flag |
| cap_rd_i | input | 1 | Capture register read strobe |
| hold_rd_i | input | 1 | Holding register read strobe |
| cap_o | output | TW (16) | Capture register |
| hold_o | output | TW (16) | Holding register |
| flag_o | output | 1 | Channel flag |
| pol_o | output | 1 | Polarity of the first capture |
| irq_o | output | 1 | Interrupt request |

## Verification
With the filter off, capture, flag and polarity results appear four clock edges after the edge that first samples a new pin level. That is two synchroniser flops, one registered edge pulse and the register write. The bench holds `timer_i` steady around every pin change and samples six cycles later, on a falling edge. With the filter on, the result is due about three cycles after the count ends. The bench samples at a point well short of the count to confirm that nothing was captured yet, and again well past it. Strobes such as clear, read and latch act at the next rising edge, and the bench samples each one a cycle after its pulse.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic acc;
        logic rise;
    } edge_evt_t;

    function automatic logic edge_pass(edge_sel_e sel, logic rise);
        case (sel)
            EDGE_RISE: edge_pass = rise;
            EDGE_FALL: edge_pass = !rise;
            EDGE_ANY:  edge_pass = 1'b1;
            default:   edge_pass = 1'b0;
        endcase
    endfunction

    function automatic int unsigned dly_len(logic [1:0] sel, int unsigned base);
        case (sel)
            2'b01:   dly_len = base;
            2'b10:   dly_len = base * 2;
            2'b11:   dly_len = base * 4;
            default: dly_len = 1;
        endcase
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_edge_filt.sv
module cap_edge_filt
    import cap_pkg::*;
#(
    parameter int DLY_BASE = 256
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      lvl_i,
    input  logic [1:0] edge_sel_i,
    input  logic [1:0] dly_sel_i,
    output edge_evt_t evt_o
);
    localparam int CW = $clog2(4 * DLY_BASE) + 1;

    logic          ref_q, prev_q, base_q, busy_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_cnt;
    edge_sel_e     sel;

    assign sel      = edge_sel_e'(edge_sel_i);
    assign last_cnt = CW'(dly_len(dly_sel_i, DLY_BASE) - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= 1'b0;
            prev_q <= 1'b0;
            base_q <= 1'b0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
            evt_o  <= '0;
        end else begin
            prev_q    <= lvl_i;
            evt_o.acc <= 1'b0;
            if (dly_sel_i == 2'b00) begin
                busy_q <= 1'b0;
                if (lvl_i != ref_q) begin
                    ref_q      <= lvl_i;
                    evt_o.acc  <= edge_pass(sel, lvl_i);
                    evt_o.rise <= lvl_i;
                end
            end else if (!busy_q) begin
                if (lvl_i != ref_q) begin
                    busy_q <= 1'b1;
                    base_q <= ref_q;
                    cnt_q  <= '0;
                end
            end else if (lvl_i != prev_q) begin
                cnt_q <= '0;
            end else if (cnt_q >= last_cnt) begin
                busy_q <= 1'b0;
                ref_q  <= lvl_i;
                if (lvl_i != base_q) begin
                    evt_o.acc  <= edge_pass(sel, lvl_i);
                    evt_o.rise <= lvl_i;
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cap_store.sv
module cap_store #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_i,
    input  logic [TW-1:0] ts_i,
    input  logic          buf_en_i,
    input  logic          latch_mode_i,
    input  logic          no_ovw_i,
    input  logic          latch_i,
    input  logic          cap_rd_i,
    input  logic          hold_rd_i,
    output logic [TW-1:0] cap_o,
    output logic [TW-1:0] hold_o,
    output logic          cap_wr_o,
    output logic          xfer_o
);
    logic queue_m, latch_m, cap_full_q, hold_full_q, latch_go;

    assign queue_m  = buf_en_i && !latch_mode_i;
    assign latch_m  = buf_en_i && latch_mode_i;
    assign latch_go = latch_m && latch_i;

    always_comb begin
        cap_wr_o = 1'b0;
        xfer_o   = latch_go;
        if (acc_i) begin
            if (queue_m) begin
                if (!no_ovw_i || !hold_full_q && cap_full_q) begin
                    cap_wr_o = 1'b1;
                    xfer_o   = 1'b1;
                end else if (!cap_full_q) begin
                    cap_wr_o = 1'b1;
                end
            end else begin
                cap_wr_o = !(no_ovw_i && cap_full_q);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_o       <= '0;
            hold_o      <= '0;
            cap_full_q  <= 1'b0;
            hold_full_q <= 1'b0;
        end else begin
            if (xfer_o)   hold_o <= cap_o;
            if (cap_wr_o) cap_o  <= ts_i;
            if (cap_wr_o)                    cap_full_q <= 1'b1;
            else if (cap_rd_i || latch_go)   cap_full_q <= 1'b0;
            if (xfer_o)         hold_full_q <= 1'b1;
            else if (hold_rd_i) hold_full_q <= 1'b0;
        end
    end
endmodule

// File: rtl/bufcap_chan.sv
module bufcap_chan
    import cap_pkg::*;
#(
    parameter int TW       = 16,
    parameter int DLY_BASE = 256,
    parameter int SYNC_N   = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pin_i,
    input  logic [TW-1:0] timer_i,
    input  logic [1:0]    edge_sel_i,
    input  logic [1:0]    dly_sel_i,
    input  logic          buf_en_i,
    input  logic          latch_mode_i,
    input  logic          no_ovw_i,
    input  logic          flag_hold_i,
    input  logic          fast_clr_i,
    input  logic          ie_i,
    input  logic          latch_stb_i,
    input  logic          force_latch_i,
    input  logic          flag_clr_i,
    input  logic          cap_rd_i,
    input  logic          hold_rd_i,
    output logic [TW-1:0] cap_o,
    output logic [TW-1:0] hold_o,
    output logic          flag_o,
    output logic          pol_o,
    output logic          irq_o
);
    logic      lvl_s, cap_wr, xfer, set_ev, clr_ev;
    edge_evt_t evt;

    cap_sync #(.STAGES(SYNC_N)) sync_i (
        .clk(clk), .rst(rst), .d_i(pin_i), .q_o(lvl_s)
    );

    cap_edge_filt #(.DLY_BASE(DLY_BASE)) filt_i (
        .clk(clk), .rst(rst), .lvl_i(lvl_s), .edge_sel_i(edge_sel_i),
        .dly_sel_i(dly_sel_i), .evt_o(evt)
    );

    cap_store #(.TW(TW)) store_i (
        .clk(clk), .rst(rst), .acc_i(evt.acc), .ts_i(timer_i),
        .buf_en_i(buf_en_i), .latch_mode_i(latch_mode_i), .no_ovw_i(no_ovw_i),
        .latch_i(latch_stb_i || force_latch_i), .cap_rd_i(cap_rd_i),
        .hold_rd_i(hold_rd_i), .cap_o(cap_o), .hold_o(hold_o),
        .cap_wr_o(cap_wr), .xfer_o(xfer)
    );

    assign set_ev = (buf_en_i && !latch_mode_i && flag_hold_i) ? (xfer && evt.acc) : cap_wr;
    assign clr_ev = flag_clr_i || (fast_clr_i && cap_rd_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            pol_o  <= 1'b0;
        end else begin
            if (set_ev)      flag_o <= 1'b1;
            else if (clr_ev) flag_o <= 1'b0;
            if (cap_wr && !flag_o) pol_o <= evt.rise;
        end
    end

    assign irq_o = flag_o && ie_i;
endmodule

// File: rtl/bufcap_chan_chk.sv
module bufcap_chan_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          acc,
    input logic          buf_en_i,
    input logic          latch_mode_i,
    input logic          no_ovw_i,
    input logic          latch_stb_i,
    input logic          force_latch_i,
    input logic          flag_clr_i,
    input logic [TW-1:0] cap_o,
    input logic [TW-1:0] hold_o,
    input logic          flag_o,
    input logic          irq_o
);
    AST_CAP_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
        !acc |=> $stable(cap_o)); // R3
    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_o) |-> $past(acc)); // R3
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_i && !acc) |=> !flag_o); // R5
    AST_QUEUE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (acc && buf_en_i && !latch_mode_i && !no_ovw_i) |=> (hold_o == $past(cap_o))); // R6
    AST_LATCH_COPY: assert property (@(posedge clk) disable iff (rst)
        (buf_en_i && latch_mode_i && (latch_stb_i || force_latch_i)) |=> (hold_o == $past(cap_o))); // R7
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !buf_en_i |=> $stable(hold_o)); // R12
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> flag_o); // R13
endmodule

bind bufcap_chan bufcap_chan_chk #(.TW(TW)) chk_i (
    .clk(clk), .rst(rst), .acc(evt.acc), .buf_en_i(buf_en_i),
    .latch_mode_i(latch_mode_i), .no_ovw_i(no_ovw_i), .latch_stb_i(latch_stb_i),
    .force_latch_i(force_latch_i), .flag_clr_i(flag_clr_i), .cap_o(cap_o),
    .hold_o(hold_o), .flag_o(flag_o), .irq_o(irq_o)
);

// File: tb/bufcap_chan_tb_top.sv
module bufcap_chan_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pin = 1'b0;
    logic [15:0] timer = '0;
    logic [1:0]  esel = 2'b00, dsel = 2'b00;
    logic        buf_en = 0, latch_mode = 0, no_ovw = 0, flag_hold = 0, fast_clr = 0, ie = 0;
    logic        latch_stb = 0, force_latch = 0, flag_clr = 0, cap_rd = 0, hold_rd = 0;
    logic [15:0] cap, hold;
    logic        flag, pol, irq;
    int          nchk = 0, nfail = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    bufcap_chan dut_i (
        .clk(clk), .rst(rst), .pin_i(pin), .timer_i(timer), .edge_sel_i(esel),
        .dly_sel_i(dsel), .buf_en_i(buf_en), .latch_mode_i(latch_mode),
        .no_ovw_i(no_ovw), .flag_hold_i(flag_hold), .fast_clr_i(fast_clr),
        .ie_i(ie), .latch_stb_i(latch_stb), .force_latch_i(force_latch),
        .flag_clr_i(flag_clr), .cap_rd_i(cap_rd), .hold_rd_i(hold_rd),
        .cap_o(cap), .hold_o(hold), .flag_o(flag), .pol_o(pol), .irq_o(irq)
    );

    function automatic logic exp_hit(logic [1:0] sel, logic oldv, logic newv);
        return (oldv != newv) && ((newv && sel[0]) || (!newv && sel[1]));
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic move_pin(input logic v, input logic [15:0] ts);
        timer = ts; pin = v; tick(6);
    endtask

    task automatic clear_flag();
        flag_clr = 1; tick(1); flag_clr = 0; tick(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        tick(3); rst = 0; tick(1);
        chk("R1 cap", 32'(cap), 0); chk("R1 hold", 32'(hold), 0);
        chk("R1 flag", 32'(flag), 0); chk("R1 pol", 32'(pol), 0); chk("R1 irq", 32'(irq), 0);

        // plain capture, rising only
        esel = 2'b01; ie = 1;
        move_pin(1, 16'h1234);
        chk("R3 cap", 32'(cap), 32'h1234); chk("R3 flag", 32'(flag), 1);
        chk("R13 irq", 32'(irq), 1); chk("R10 pol rise", 32'(pol), 1);
        move_pin(0, 16'h2222);
        chk("R2 rise-only ignores fall", 32'(cap), 32'h1234);
        chk("R12 hold idle", 32'(hold), 0);
        ie = 0; tick(1); chk("R13 masked", 32'(irq), 0); ie = 1;
        clear_flag();
        chk("R5 flag cleared", 32'(flag), 0); chk("R13 irq low", 32'(irq), 0);

        // falling only
        esel = 2'b10;
        move_pin(1, 16'h3333);
        chk("R2 fall-only ignores rise", 32'(cap), 32'h1234); chk("R2 no flag", 32'(flag), 0);
        move_pin(0, 16'h4444);
        chk("R2 fall cap", 32'(cap), 32'h4444); chk("R10 pol fall", 32'(pol), 0);
        clear_flag();

        // disabled
        esel = 2'b00;
        move_pin(1, 16'h5555); move_pin(0, 16'h6666);
        chk("R2 off cap", 32'(cap), 32'h4444); chk("R2 off flag", 32'(flag), 0);

        // any edge, polarity kept while flag set
        esel = 2'b11;
        move_pin(1, 16'h7001);
        chk("R10 first pol", 32'(pol), 1);
        move_pin(0, 16'h7002);
        chk("R2 any cap", 32'(cap), 32'h7002); chk("R10 pol kept", 32'(pol), 1);
        clear_flag();

        // fast clear
        move_pin(1, 16'h8001);
        cap_rd = 1; tick(1); cap_rd = 0; tick(1);
        chk("R11 read without fast clear", 32'(flag), 1);
        fast_clr = 1; cap_rd = 1; tick(1); cap_rd = 0; tick(1); fast_clr = 0;
        chk("R11 fast clear", 32'(flag), 0);

        // queue mode
        buf_en = 1; latch_mode = 0;
        move_pin(0, 16'hA000);
        chk("R6 hold old", 32'(hold), 32'h8001); chk("R6 cap new", 32'(cap), 32'hA000);
        move_pin(1, 16'hB000);
        chk("R6 hold shift", 32'(hold), 32'hA000); chk("R6 cap shift", 32'(cap), 32'hB000);

        // no-overwrite and flag-on-transfer in queue mode
        no_ovw = 1; flag_hold = 1;
        cap_rd = 1; hold_rd = 1; tick(1); cap_rd = 0; hold_rd = 0;
        clear_flag();
        move_pin(0, 16'hC000);
        chk("R9 no flag without transfer", 32'(flag), 0);
        chk("R8 cap empty load", 32'(cap), 32'hC000); chk("R8 hold kept", 32'(hold), 32'hA000);
        move_pin(1, 16'hD000);
        chk("R9 flag on transfer", 32'(flag), 1);
        chk("R8 shift when hold empty", 32'(hold), 32'hC000);
        move_pin(0, 16'hE000);
        chk("R8 drop cap", 32'(cap), 32'hD000); chk("R8 drop hold", 32'(hold), 32'hC000);
        hold_rd = 1; tick(1); hold_rd = 0;
        move_pin(1, 16'hF000);
        chk("R8 after hold read", 32'(hold), 32'hD000); chk("R8 cap after", 32'(cap), 32'hF000);
        no_ovw = 0; flag_hold = 0;

        // latch mode
        latch_mode = 1;
        move_pin(0, 16'h0101);
        chk("R7 edge leaves hold", 32'(hold), 32'hD000); chk("R7 cap", 32'(cap), 32'h0101);
        latch_stb = 1; tick(1); latch_stb = 0; tick(1);
        chk("R7 strobe latch", 32'(hold), 32'h0101);
        move_pin(1, 16'h0202);
        force_latch = 1; tick(1); force_latch = 0; tick(1);
        chk("R7 force latch", 32'(hold), 32'h0202);
        no_ovw = 1;
        move_pin(0, 16'h0303);
        move_pin(1, 16'h0404);
        chk("R8 latch mode protect", 32'(cap), 32'h0303);
        latch_stb = 1; tick(1); latch_stb = 0; tick(1);
        chk("R8 latch empties", 32'(hold), 32'h0303);
        move_pin(0, 16'h0505);
        chk("R8 write after latch", 32'(cap), 32'h0505);
        no_ovw = 0; buf_en = 0; latch_mode = 0;

        // delay filter
        clear_flag();
        dsel = 2'b01; timer = 16'h9999;
        pin = 1; tick(40); pin = 0; tick(300);
        chk("R4 short pulse rejected", 32'(flag), 0);
        chk("R4 cap kept", 32'(cap), 32'h0505);
        pin = 1; tick(200);
        chk("R4 not before 256", 32'(flag), 0);
        tick(100);
        chk("R4 accepted 256", 32'(flag), 1); chk("R4 cap value", 32'(cap), 32'h9999);
        clear_flag();
        dsel = 2'b11; timer = 16'h7777;
        pin = 0; tick(1000);
        chk("R4 not before 1024", 32'(flag), 0);
        tick(60);
        chk("R4 accepted 1024", 32'(flag), 1); chk("R4 cap 1024", 32'(cap), 32'h7777);
        dsel = 2'b00;

        // constrained random, plain mode
        void'($urandom(32'd2024));
        for (int i = 0; i < 200; i++) begin
            logic [1:0]  s;
            logic        nv, ov, hit;
            logic [15:0] ts, prev;
            clear_flag();
            s = 2'($urandom_range(3)); nv = 1'($urandom_range(1));
            ts = 16'($urandom); ov = pin; prev = cap;
            hit = exp_hit(s, ov, nv);
            esel = s;
            move_pin(nv, ts);
            chk("R2 rand cap", 32'(cap), hit ? 32'(ts) : 32'(prev));
            chk("R3 rand flag", 32'(flag), 32'(hit));
            if (hit) chk("R10 rand pol", 32'(pol), 32'(nv));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule